// File: doc/BRIEF.md
# Interrupt Throttling and Message Dispatch for a Network Adapter

This block sits between the receive/transmit queue engines of a network adapter and the bus interface that sends interrupt messages to the host. A queue that wants the host's attention raises a request naming an interrupt vector and a throttle selector. The block drops the request unless the queue's own cause enable and the global interrupt enable are both set. It then looks up the minimum spacing programmed for that vector and selector, and arms a timer for the vector. When the timer runs out, the block emits one interrupt message on a valid/ready channel. The message carries the vector number and a flag that says whether it is an MSI-X or a plain MSI message.

Requests that reach a vector that is already armed are folded into the interrupt that is already waiting, so a burst of completions costs one message. Vector 0 has three interval registers of its own and keeps a cause register that software reads to learn which queue fired. A read of the cause register also clears it. All other vectors take their intervals from a table indexed by selector and vector. The host's MSI-X enable is sampled when the timer expires, not when the request arrives. With MSI-X off, only vector 0 can be delivered, as an MSI. An expiry on any other vector is reported as an error.

Top module: `irq_moderator`

## Requirements
- R1: After reset, `msg_valid` and `err_bad_vec` are 0, `reg_rdata` reads 0, and the cause register (word address 1) reads 0.
- R2: A request has no effect unless `req_cause_en` is 1 and bit 0 of the global control register (word address 0) is 1. A dropped request produces no message and leaves the cause register unchanged.
- R3: For a selector of 0, 1 or 2 with programmed count C, the message appears between C·T+2 and C·T+T+1 cycles after the cycle in which the request is sampled, where T is `TICKS_PER_UNIT` and the output is free. This puts at least C time units between request and message.
- R4: Vector 0 takes its intervals from word addresses 4, 5 and 6 (selectors 0, 1, 2). Vector v > 0 with selector s uses the table word at 2^(VEC_W+2) + s·2^VEC_W + v. All of these words can be written and read back.
- R5: Selector 3 bypasses throttling: the message is valid one cycle after the request is sampled.
- R6: A request to a vector that is armed or already has a message pending does not restart the timer and does not add a message.
- R7: With `host_msix_en` set at expiry, the message carries the vector number and `msg_is_msix` = 1.
- R8: With `host_msix_en` clear at expiry, vector 0 is sent with `msg_is_msix` = 0. The state of the enable at request time does not matter.
- R9: With `host_msix_en` clear at expiry of a nonzero vector, no message is sent and `err_bad_vec` pulses for one cycle, in the cycle after the expiry.
- R10: Each accepted request on vector 0 sets cause bit 30 and cause bit 1+`req_qidx`. Requests on other vectors do not change the cause register.
- R11: Reading the cause register returns its value and leaves it 0, unless a new vector-0 request sets bits in the same cycle.
- R12: While `msg_valid` is 1 and `msg_ready` is 0, the message holds steady. Among pending vectors, the lowest number is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_msix_en | input | 1 | Host device-control flag: MSI-X delivery enabled |
| req_valid | input | 1 | Queue interrupt request strobe |
| req_vec | input | VEC_W | Requested vector |
| req_thr | input | 2 | Throttle selector (3 = none) |
| req_cause_en | input | 1 | Queue cause enable |
| req_qidx | input | QIDX_W | Queue index for the vector-0 cause bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vec | output | VEC_W | Message vector |
| msg_is_msix | output | 1 | 1 = MSI-X, 0 = MSI |
| err_bad_vec | output | 1 | Pulse: nonzero vector expired with MSI-X disabled |

## Verification
The bench builds the block with 8 vectors, 6-bit interval counts and a time unit of 4 cycles. At these values the last table vector and every table word are within reach, and every timing window is only a few cycles wide, so a wrong count or a wrong lookup moves the message out of its window. A scoreboard holds each expected message with its vector, type and cycle window, and the monitor rejects any message it did not predict. Flipping the MSI-X enable between request and expiry shows that the mode is taken at expiry.

// File: rtl/irq_mod_pkg.sv
// Package: constants shared by the interrupt throttling block.
// Assumes 32-bit registers; word offsets in the low register region.
package irq_mod_pkg;
    localparam int REG_W         = 32;
    localparam int CAUSE_EVT_BIT = 30;
    localparam int CAUSE_Q0_BIT  = 1;
    localparam int OFS_GCTL      = 0;
    localparam int OFS_CAUSE     = 1;
    localparam int OFS_V0_ITR    = 4;

    typedef enum logic [1:0] {
        THR_A    = 2'd0,
        THR_B    = 2'd1,
        THR_C    = 2'd2,
        THR_NONE = 2'd3
    } thr_sel_e;
endpackage

// File: rtl/irq_tick_gen.sv
// Free-running time base: pulses tick once every TICKS cycles.
// Assumes TICKS >= 1; the pulse does not depend on any request.
module irq_tick_gen #(
    parameter int TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(TICKS - 1));

    // Count cycles within one time unit and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/irq_regs.sv
// Register file: global control, cause register (clear on read), the
// three vector-0 interval registers and the per-selector vector table.
// It also gives the interval lookup for the incoming request.
// Assumes read data is registered and valid the cycle after reg_rd.
module irq_regs
    import irq_mod_pkg::*;
#(
    parameter int NUM_VEC   = 128,
    parameter int ITR_W     = 12,
    parameter int NUM_QBITS = 8,
    parameter int VEC_W     = 7,
    parameter int ADDR_W    = 10,
    parameter int QIDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              acc,
    input  logic [VEC_W-1:0]  lk_vec,
    input  logic [1:0]        lk_thr,
    input  logic [QIDX_W-1:0] lk_qidx,
    output logic [ITR_W-1:0]  lk_len,
    output logic              glb_en,
    output logic [REG_W-1:0]  cause_val
);
    localparam int LO_W = ADDR_W - 1;

    logic [REG_W-1:0] gctl_q;
    logic [REG_W-1:0] cause_q;
    logic [ITR_W-1:0] v0_itr [3];
    logic [ITR_W-1:0] tbl    [3][NUM_VEC];

    logic             is_tbl;
    logic [1:0]       t_idx;
    logic [VEC_W-1:0] t_vec;
    logic [LO_W-1:0]  lo_ofs;
    logic             tbl_hit;
    logic             sel_gctl, sel_cause, sel_v0;
    logic [1:0]       v0_idx;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] set_bits;

    // Split the address into the low region and the table fields.
    always_comb begin
        is_tbl    = reg_addr[ADDR_W-1];
        t_idx     = reg_addr[VEC_W+1:VEC_W];
        t_vec     = reg_addr[VEC_W-1:0];
        lo_ofs    = reg_addr[LO_W-1:0];
        tbl_hit   = is_tbl && (t_idx != 2'd3) && (int'(t_vec) < NUM_VEC);
        sel_gctl  = !is_tbl && (lo_ofs == LO_W'(OFS_GCTL));
        sel_cause = !is_tbl && (lo_ofs == LO_W'(OFS_CAUSE));
        sel_v0    = !is_tbl && (lo_ofs >= LO_W'(OFS_V0_ITR))
                            && (lo_ofs <  LO_W'(OFS_V0_ITR + 3));
        v0_idx    = 2'(lo_ofs - LO_W'(OFS_V0_ITR));
    end

    // Interval lookup for the request: vector 0 has its own registers.
    always_comb begin
        lk_len = '0;
        if (lk_thr != THR_NONE) begin
            if (lk_vec == '0) lk_len = v0_itr[lk_thr];
            else              lk_len = tbl[lk_thr][lk_vec];
        end
    end

    // Cause bits raised by an accepted vector-0 request.
    always_comb begin
        set_bits = '0;
        if (acc && lk_vec == '0)
            set_bits = (REG_W'(1) << CAUSE_EVT_BIT)
                     | (REG_W'(1) << (CAUSE_Q0_BIT + int'(lk_qidx)));
    end

    // Read-data multiplexer.
    always_comb begin
        rd_val = '0;
        if (tbl_hit)        rd_val = REG_W'(tbl[t_idx][t_vec]);
        else if (sel_gctl)  rd_val = gctl_q;
        else if (sel_cause) rd_val = cause_q;
        else if (sel_v0)    rd_val = REG_W'(v0_itr[v0_idx]);
    end

    // Global control and interval storage writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= '0;
            for (int i = 0; i < 3; i++) begin
                v0_itr[i] <= '0;
                for (int v = 0; v < NUM_VEC; v++) tbl[i][v] <= '0;
            end
        end else if (reg_wr) begin
            if (sel_gctl) gctl_q <= reg_wdata;
            if (sel_v0)   v0_itr[v0_idx] <= reg_wdata[ITR_W-1:0];
            if (tbl_hit)  tbl[t_idx][t_vec] <= reg_wdata[ITR_W-1:0];
        end
    end

    // Cause register: write, clear on read, and set by new events.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cause_q <= '0;
        else if (reg_wr && sel_cause) cause_q <= reg_wdata | set_bits;
        else if (reg_rd && sel_cause) cause_q <= set_bits;
        else                        cause_q <= cause_q | set_bits;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    assign glb_en    = gctl_q[0];
    assign cause_val = cause_q;
endmodule

// File: rtl/irq_vec_timers.sv
// Per-vector throttle timers. An accepted request arms an idle vector
// with its interval, or marks it expired at once for selector 3. A
// request to a vector that is armed or pending is merged. On expiry
// the delivery mode is taken from the MSI-X enable; a nonzero vector
// with MSI-X off raises the error pulse instead of pending.
// Assumes the dispatcher only takes vectors whose pend bit is set.
module irq_vec_timers #(
    parameter int NUM_VEC = 128,
    parameter int ITR_W   = 12,
    parameter int VEC_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               msix_en,
    input  logic               arm_req,
    input  logic [VEC_W-1:0]   arm_vec,
    input  logic [1:0]         arm_thr,
    input  logic [ITR_W-1:0]   arm_len,
    input  logic               take,
    input  logic [VEC_W-1:0]   take_vec,
    output logic [NUM_VEC-1:0] armed,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] ptype,
    output logic               err_bad
);
    logic [NUM_VEC-1:0] bad_v;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic [ITR_W-1:0] rem_q;
        logic             hit, now, load, expire;

        // Decide arming, immediate fire and timer expiry for this vector.
        always_comb begin
            hit      = arm_req && (arm_vec == VEC_W'(v)) && !armed[v] && !pend[v];
            now      = hit && (arm_thr == 2'd3);
            load     = hit && (arm_thr != 2'd3);
            expire   = now || (armed[v] && tick && rem_q == '0);
            bad_v[v] = expire && !msix_en && (v != 0);
        end

        // Countdown of remaining time units while armed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed[v] <= 1'b0;
                rem_q    <= '0;
            end else if (load) begin
                armed[v] <= 1'b1;
                rem_q    <= arm_len;
            end else if (armed[v] && tick) begin
                if (rem_q == '0) armed[v] <= 1'b0;
                else             rem_q    <= rem_q - 1'b1;
            end
        end

        // Pending message flag and its delivery type.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[v]  <= 1'b0;
                ptype[v] <= 1'b0;
            end else if (expire && !bad_v[v]) begin
                pend[v]  <= 1'b1;
                ptype[v] <= msix_en;
            end else if (take && take_vec == VEC_W'(v)) begin
                pend[v]  <= 1'b0;
            end
        end
    end

    // One-cycle error pulse after any refused expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) err_bad <= 1'b0;
        else        err_bad <= |bad_v;
    end
endmodule

// File: rtl/irq_dispatch.sv
// Output stage: picks the lowest pending vector and holds it in the
// message register until the consumer takes it.
// Assumes pend bits stay set until this stage reports take.
module irq_dispatch #(
    parameter int NUM_VEC = 128,
    parameter int VEC_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] ptype,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [VEC_W-1:0]   msg_vec,
    output logic               msg_is_msix,
    output logic               take,
    output logic [VEC_W-1:0]   take_vec
);
    logic load;

    // Fixed priority: the lowest pending vector wins.
    always_comb begin
        take_vec = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--)
            if (pend[i]) take_vec = VEC_W'(i);
        load = !msg_valid || msg_ready;
        take = load && (|pend);
    end

    // Message register, reloaded when empty or accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid   <= 1'b0;
            msg_vec     <= '0;
            msg_is_msix <= 1'b0;
        end else if (load) begin
            msg_valid <= |pend;
            if (|pend) begin
                msg_vec     <= take_vec;
                msg_is_msix <= ptype[take_vec];
            end
        end
    end
endmodule

// File: rtl/irq_moderator.sv
// Top: gates queue requests with the cause and global enables, looks
// up the throttle interval and drives the per-vector timers and the
// message output. Assumes a single request port, one request per cycle.
module irq_moderator
    import irq_mod_pkg::*;
#(
    parameter int NUM_VEC        = 128,
    parameter int ITR_W          = 12,
    parameter int TICKS_PER_UNIT = 500,
    parameter int NUM_QBITS      = 8,
    parameter int VEC_W          = $clog2(NUM_VEC),
    parameter int ADDR_W         = VEC_W + 3,
    parameter int QIDX_W         = $clog2(NUM_QBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_msix_en,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [1:0]        req_thr,
    input  logic              req_cause_en,
    input  logic [QIDX_W-1:0] req_qidx,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vec,
    output logic              msg_is_msix,
    output logic              err_bad_vec
);
    logic               tick;
    logic               glb_en;
    logic               acc;
    logic [ITR_W-1:0]   lk_len;
    logic [REG_W-1:0]   cause_val;
    logic [NUM_VEC-1:0] armed_vec, pend_vec, ptype_vec;
    logic               take;
    logic [VEC_W-1:0]   take_vec;

    // A request counts only with both enables set.
    assign acc = req_valid && req_cause_en && glb_en;

    irq_tick_gen #(.TICKS(TICKS_PER_UNIT)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    irq_regs #(
        .NUM_VEC(NUM_VEC), .ITR_W(ITR_W), .NUM_QBITS(NUM_QBITS),
        .VEC_W(VEC_W), .ADDR_W(ADDR_W), .QIDX_W(QIDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc(acc), .lk_vec(req_vec), .lk_thr(req_thr), .lk_qidx(req_qidx),
        .lk_len(lk_len), .glb_en(glb_en), .cause_val(cause_val)
    );

    irq_vec_timers #(.NUM_VEC(NUM_VEC), .ITR_W(ITR_W), .VEC_W(VEC_W)) u_timers (
        .clk(clk), .rst_n(rst_n), .tick(tick), .msix_en(host_msix_en),
        .arm_req(acc), .arm_vec(req_vec), .arm_thr(req_thr), .arm_len(lk_len),
        .take(take), .take_vec(take_vec),
        .armed(armed_vec), .pend(pend_vec), .ptype(ptype_vec),
        .err_bad(err_bad_vec)
    );

    irq_dispatch #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .pend(pend_vec), .ptype(ptype_vec),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vec(msg_vec),
        .msg_is_msix(msg_is_msix), .take(take), .take_vec(take_vec)
    );
endmodule

// File: rtl/irq_moderator_chk.sv
// Checker for irq_moderator: protocol, delivery-mode and cause-register
// properties. Attached to every irq_moderator instance by bind.
module irq_moderator_chk #(
    parameter int NUM_VEC = 128,
    parameter int VEC_W   = 7,
    parameter int ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_msix_en,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vec,
    input logic               req_cause_en,
    input logic               glb_en,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [VEC_W-1:0]   msg_vec,
    input logic               msg_is_msix,
    input logic               err_bad_vec,
    input logic [31:0]        cause_val,
    input logic [NUM_VEC-1:0] armed_vec,
    input logic [NUM_VEC-1:0] pend_vec
);
    localparam logic [ADDR_W-1:0] CAUSE_ADDR = ADDR_W'(1);

    // R12: a stalled message keeps its content.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) && $stable(msg_is_msix));

    // R8: a plain MSI message always names vector 0.
    a_r8_msi_vec0: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_is_msix |-> msg_vec == '0);

    // R9: the error pulse follows an expiry with MSI-X off.
    a_r9_err_msix_off: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad_vec |-> !$past(host_msix_en));

    // R11: a cause read without a concurrent vector-0 event leaves it clear.
    a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !reg_wr && reg_addr == CAUSE_ADDR &&
        !(req_valid && req_cause_en && glb_en && req_vec == '0) |=> cause_val == '0);

    // R2: a dropped request leaves the cause register alone.
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_cause_en && glb_en) && !reg_rd && !reg_wr |=> $stable(cause_val));

    // R6: a vector is never both counting and waiting for delivery.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_vec & pend_vec) == '0);
endmodule

bind irq_moderator irq_moderator_chk #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_msix_en(host_msix_en),
    .req_valid(req_valid), .req_vec(req_vec), .req_cause_en(req_cause_en),
    .glb_en(glb_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
    .msg_is_msix(msg_is_msix), .err_bad_vec(err_bad_vec),
    .cause_val(cause_val), .armed_vec(armed_vec), .pend_vec(pend_vec)
);

// File: tb/irq_moderator_bench.sv
// Scoreboard bench for irq_moderator: driver tasks queue expected
// messages with cycle windows, a monitor pops and compares them.
module irq_moderator_bench;
    localparam int NV  = 8;
    localparam int IW  = 6;
    localparam int TPU = 4;
    localparam int NQ  = 8;
    localparam int VW  = 3;
    localparam int AW  = 6;
    localparam int QW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_msix_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vec = '0;
    logic [1:0]    req_thr = '0;
    logic          req_cause_en = 1'b0;
    logic [QW-1:0] req_qidx = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid, msg_ready = 1'b1, msg_is_msix, err_bad_vec;
    logic [VW-1:0] msg_vec;

    irq_moderator #(.NUM_VEC(NV), .ITR_W(IW), .TICKS_PER_UNIT(TPU), .NUM_QBITS(NQ))
    u_irq_moderator (
        .clk(clk), .rst_n(rst_n), .host_msix_en(host_msix_en),
        .req_valid(req_valid), .req_vec(req_vec), .req_thr(req_thr),
        .req_cause_en(req_cause_en), .req_qidx(req_qidx),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
        .msg_is_msix(msg_is_msix), .err_bad_vec(err_bad_vec)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    vec;
        bit    msix;
        int    lo;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0, n_fail = 0, err_seen = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int taddr(input int s, input int v);
        return (1 << (VW + 2)) + s * (1 << VW) + v;
    endfunction

    task automatic wr(input int a, input int d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = AW'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic req(input int v, input int s, input bit ce, input int q, output int t);
        req_valid = 1'b1; req_vec = VW'(v); req_thr = 2'(s);
        req_cause_en = ce; req_qidx = QW'(q);
        @(negedge clk);
        t = cyc;
        req_valid = 1'b0;
    endtask

    task automatic expect_msg(input int v, input bit mx, input int lo, input int hi, input string tag);
        exp_t e;
        e.vec = v; e.msix = mx; e.lo = lo; e.hi = hi; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every accepted message against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (err_bad_vec) err_seen++;
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R9 unexpected message", longint'(msg_vec), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(msg_vec) == e.vec, {e.tag, " vector"}, msg_vec, e.vec);
                    check(msg_is_msix == e.msix, {e.tag, " type"}, msg_is_msix, e.msix);
                    check(cyc >= e.lo && cyc <= e.hi, {e.tag, " timing"}, cyc, e.lo);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t, t2, t3;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(msg_valid == 1'b0, "R1 msg_valid", msg_valid, 0);
        check(err_bad_vec == 1'b0, "R1 err", err_bad_vec, 0);
        check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 0);
        rd(1, d); check(d == 32'h0, "R1 cause", d, 0);

        // R4: program intervals and read back
        host_msix_en = 1'b1;
        wr(0, 1);
        wr(4, 2); wr(5, 3); wr(6, 5);
        wr(taddr(0, 3), 1); wr(taddr(1, 3), 4);
        wr(taddr(2, 7), 2); wr(taddr(0, 5), 3);
        rd(5, d); check(d == 32'd3, "R4 v0 sel1 readback", d, 3);
        rd(taddr(2, 7), d); check(d == 32'd2, "R4 table v7 sel2 readback", d, 2);
        rd(6, d); check(d == 32'd5, "R4 v0 sel2 readback", d, 5);

        // R3, R7: throttled MSI-X messages, windows C*T+2 .. C*T+T+1
        req(3, 0, 1'b1, 0, t); expect_msg(3, 1, t + 6, t + 9, "R3 v3 sel0");
        idle(14);
        req(3, 1, 1'b1, 0, t); expect_msg(3, 1, t + 18, t + 21, "R3 v3 sel1");
        idle(26);
        req(7, 2, 1'b1, 0, t); expect_msg(7, 1, t + 10, t + 13, "R7 v7 sel2");
        idle(18);
        req(0, 1, 1'b1, 2, t); expect_msg(0, 1, t + 14, t + 17, "R4 v0 sel1");
        idle(22);

        // R10 / R11: cause set by vector 0, cleared by read
        rd(1, d); check(d == 32'h4000_0008, "R10 cause bits", d, 32'h4000_0008);
        rd(1, d); check(d == 32'h0, "R11 cause cleared", d, 0);
        req(5, 0, 1'b1, 4, t); expect_msg(5, 1, t + 14, t + 17, "R3 v5 sel0");
        rd(1, d); check(d == 32'h0, "R10 other vector no cause", d, 0);
        idle(22);

        // R5: no throttle
        req(6, 3, 1'b1, 0, t); expect_msg(6, 1, t + 1, t + 1, "R5 v6 immediate");
        idle(3);
        req(0, 3, 1'b1, 0, t); expect_msg(0, 1, t + 1, t + 1, "R5 v0 immediate");
        idle(4);

        // R6: merge into armed vector
        req(5, 0, 1'b1, 0, t); expect_msg(5, 1, t + 14, t + 17, "R6 merged v5");
        idle(3);
        req(5, 3, 1'b1, 0, t2);
        idle(2);
        req(5, 1, 1'b1, 0, t2);
        idle(30);
        check(exp_q.size() == 0, "R6 single message", exp_q.size(), 0);

        // R2: gating by global enable and cause enable
        rd(1, d);
        wr(0, 0);
        req(6, 3, 1'b1, 0, t);
        req(0, 3, 1'b1, 1, t);
        idle(3);
        rd(1, d); check(d == 32'h0, "R2 global off no cause", d, 0);
        wr(0, 1);
        req(0, 3, 1'b0, 1, t);
        idle(3);
        rd(1, d); check(d == 32'h0, "R2 cause_en off no cause", d, 0);
        idle(8);
        check(exp_q.size() == 0, "R2 no message", exp_q.size(), 0);

        // R8: mode sampled at expiry, vector 0 goes out as MSI
        req(0, 0, 1'b1, 0, t); expect_msg(0, 0, t + 10, t + 13, "R8 v0 msi at expiry");
        idle(3);
        host_msix_en = 1'b0;
        idle(16);
        req(0, 3, 1'b1, 0, t); expect_msg(0, 0, t + 1, t + 1, "R8 v0 msi immediate");
        idle(4);

        // R9: nonzero vector with MSI-X off
        e0 = err_seen;
        req(3, 3, 1'b1, 0, t);
        idle(4);
        check(err_seen == e0 + 1, "R9 err immediate", err_seen, e0 + 1);
        host_msix_en = 1'b1;
        req(7, 2, 1'b1, 0, t);
        idle(3);
        host_msix_en = 1'b0;
        idle(16);
        check(err_seen == e0 + 2, "R9 err at expiry", err_seen, e0 + 2);
        check(exp_q.size() == 0, "R9 no message", exp_q.size(), 0);

        // R12: stall, hold and lowest-first order
        host_msix_en = 1'b1;
        msg_ready = 1'b0;
        req(5, 3, 1'b1, 0, t);
        req(3, 3, 1'b1, 0, t2);
        req(2, 3, 1'b1, 0, t3);
        expect_msg(5, 1, t + 1, t + 100, "R12 first");
        expect_msg(2, 1, t + 1, t + 100, "R12 lowest next");
        expect_msg(3, 1, t + 1, t + 100, "R12 last");
        idle(5);
        check(msg_valid == 1'b1 && msg_vec == VW'(5), "R12 hold", msg_vec, 5);
        msg_ready = 1'b1;
        idle(10);
        check(exp_q.size() == 0, "R12 all delivered", exp_q.size(), 0);
        check(err_seen == e0 + 2, "R9 no extra errors", err_seen, e0 + 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule